// File: doc/BRIEF.md
# Serial Inner-Product and Scale-Factor Recurrence Unit

This block supplies the scalar side of a division-free inversion that rebuilds a covariance-style inverse from rank-one updates. Each iteration it takes two M-element complex vectors: a row produced by an upstream matrix-vector stage, and the current channel vector. It forms their element-wise product sum v, using a single complex multiply-accumulate cell. A counter-driven multiplexer feeds that cell one element pair per clock, so the vectors are taken in serially.

The real part of v then drives a multiplicative recurrence on a running scale factor. The factor starts at one and, on each update, becomes `alpha * (alpha + v)`. This recurrence takes the place of the reciprocal found in the textbook rank-one update formula. An external sequencer owns the timing and drives:
- a clear and an enable for the accumulator;
- a load, a clear and an enable for the scale register.

A one-cycle done flag confirms each scale update. All values are two's-complement fixed point with `FRAC` fraction bits.

Top module: `quad_scale_unit`

## Requirements
- R1: After reset, alpha_o equals 1.0 (the value 2^FRAC), v_o is 0 and done_o is 0.
- R2: Each clock with mac_en_i high feeds one element pair into the MAC. The pairs go in index order 0, 1, …, M-1 and then wrap back to index 0. A clock with mac_clr_i high makes the next enabled clock start again at index 0.
- R3: A clock with mac_clr_i high zeroes the accumulator, whatever mac_en_i is. After n enabled clocks, v_o equals (Σ over those n clocks of x_re·c_re − x_im·c_im) arithmetically shifted right by FRAC, which rounds toward minus infinity. The imaginary part of the sum is not output.
- R4: A clock with scale_load_i high, and scale_clr_i low, sets alpha_o to 1.0. This takes precedence over scale_en_i.
- R5: A clock with scale_clr_i high sets alpha_o to 0. This overrides both scale_load_i and scale_en_i.
- R6: A clock with scale_en_i high, and both scale_load_i and scale_clr_i low, sets alpha_o to (alpha·(alpha + v_o)) arithmetically shifted right by FRAC. Both alpha and v_o are the values present before that clock.
- R7: The updated value in R6 saturates to the signed AW-bit range, [−2^(AW−1), 2^(AW−1)−1].
- R8: While mac_en_i and mac_clr_i are low, v_o holds its value. While all three scale controls are low, alpha_o holds its value.
- R9: done_o is high for exactly the one cycle that follows a clock on which an R6 update took place. It is low at all other times, including after load and clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_re_i | input | M*DW | Real parts of the row vector, element k at bits [k*DW +: DW] |
| x_im_i | input | M*DW | Imaginary parts of the row vector |
| c_re_i | input | M*DW | Real parts of the channel vector |
| c_im_i | input | M*DW | Imaginary parts of the channel vector |
| mac_clr_i | input | 1 | Zero the accumulator and rewind the element counter |
| mac_en_i | input | 1 | Accumulate the currently selected pair and advance the counter |
| scale_load_i | input | 1 | Set alpha to 1.0 |
| scale_clr_i | input | 1 | Set alpha to 0 |
| scale_en_i | input | 1 | Apply the alpha recurrence |
| v_o | output | 2*DW+clog2(M)+3−FRAC | Real part of the inner product, scaled back by FRAC |
| alpha_o | output | AW | Scale factor register |
| done_o | output | 1 | One-cycle confirmation of a recurrence update |

## Verification
The hardest situation to reach is the saturation of alpha. It cannot be driven in directly. It only appears after the recurrence has been applied several times to large inner products, since each update roughly squares the factor. The bench first reloads alpha to 1.0. It then uses full-scale real vectors with zero imaginary parts, and applies three consecutive updates, checking each one against its model until the positive limit is reached. The serial ordering is exposed through deliberately partial accumulations: one, three and M+1 enabled clocks. The first shows element 0 alone, and the last shows element 0 counted twice after the wrap.

// File: rtl/qfs_pkg.sv
package qfs_pkg;

   // Accumulator width: full product, growth over M terms, margin for the
   // three-multiplier form and at least one spare bit.
   function automatic int acc_w(input int dw, input int m);
      return 2 * dw + $clog2(m) + 3;
   endfunction

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/qfs_serializer.sv
module qfs_serializer #(
   parameter int M  = 4,
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 step,
   input  logic [M*DW-1:0]      x_re,
   input  logic [M*DW-1:0]      x_im,
   input  logic [M*DW-1:0]      c_re,
   input  logic [M*DW-1:0]      c_im,
   output logic signed [DW-1:0] sx_re,
   output logic signed [DW-1:0] sx_im,
   output logic signed [DW-1:0] sc_re,
   output logic signed [DW-1:0] sc_im
);
   localparam int SEL_W = (M > 1) ? $clog2(M) : 1;

   if (M < 1) begin : g_bad_m
      $error("qfs_serializer: M must be at least 1");
   end

   logic [SEL_W-1:0] sel_q;

   if (M == 1) begin : g_single
      assign sel_q = '0;
   end else begin : g_count
      logic [SEL_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (clr) begin
            cnt_q <= '0;
         end else if (step) begin
            if (cnt_q == SEL_W'(M - 1)) cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;
         end
      end
      assign sel_q = cnt_q;

      // R2: a clear rewinds the selection to element 0
      assert_rewind_R2: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> (cnt_q == '0));
      // R2: selection moves only when stepped
      assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && !step) |=> $stable(cnt_q));
   end

   assign sx_re = x_re[sel_q*DW +: DW];
   assign sx_im = x_im[sel_q*DW +: DW];
   assign sc_re = c_re[sel_q*DW +: DW];
   assign sc_im = c_im[sel_q*DW +: DW];

endmodule

// File: rtl/qfs_cmac.sv
module qfs_cmac #(
   parameter int DW    = 16,
   parameter int ACC_W = 37,
   parameter bit MULT3 = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    en,
   input  logic signed [DW-1:0]    a_re,
   input  logic signed [DW-1:0]    a_im,
   input  logic signed [DW-1:0]    b_re,
   input  logic signed [DW-1:0]    b_im,
   output logic signed [ACC_W-1:0] acc_re,
   output logic signed [ACC_W-1:0] acc_im
);
   localparam int PW = 2 * DW + 2;

   if (ACC_W <= PW) begin : g_bad_acc
      $error("qfs_cmac: ACC_W must exceed 2*DW+2");
   end

   logic signed [PW-1:0] p_re, p_im;

   if (MULT3) begin : g_three
      logic signed [DW:0] ar, ai, br, bi;
      logic signed [DW:0] s_a, d_b, s_b;
      logic signed [PW-1:0] k1, k2, k3;
      assign ar  = {a_re[DW-1], a_re};
      assign ai  = {a_im[DW-1], a_im};
      assign br  = {b_re[DW-1], b_re};
      assign bi  = {b_im[DW-1], b_im};
      assign s_a = ar + ai;
      assign d_b = bi - br;
      assign s_b = br + bi;
      assign k1  = br * s_a;
      assign k2  = ar * d_b;
      assign k3  = ai * s_b;
      assign p_re = k1 - k3;
      assign p_im = k1 + k2;
   end else begin : g_four
      logic signed [2*DW-1:0] rr, ii, ri, ir;
      assign rr = a_re * b_re;
      assign ii = a_im * b_im;
      assign ri = a_re * b_im;
      assign ir = a_im * b_re;
      assign p_re = {{2{rr[2*DW-1]}}, rr} - {{2{ii[2*DW-1]}}, ii};
      assign p_im = {{2{ri[2*DW-1]}}, ri} + {{2{ir[2*DW-1]}}, ir};
   end

   logic signed [ACC_W-1:0] e_re, e_im;
   assign e_re = {{(ACC_W-PW){p_re[PW-1]}}, p_re};
   assign e_im = {{(ACC_W-PW){p_im[PW-1]}}, p_im};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_re <= '0;
         acc_im <= '0;
      end else if (clr) begin
         acc_re <= '0;
         acc_im <= '0;
      end else if (en) begin
         acc_re <= acc_re + e_re;
         acc_im <= acc_im + e_im;
      end
   end

   // R3: clear wins over enable
   assert_acc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_re == '0 && acc_im == '0));
   // R8: idle accumulator keeps its value
   assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en) |=> ($stable(acc_re) && $stable(acc_im)));

endmodule

// File: rtl/qfs_scale.sv
module qfs_scale #(
   parameter int AW   = 32,
   parameter int VW   = 25,
   parameter int FRAC = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 clr,
   input  logic                 en,
   input  logic signed [VW-1:0] v,
   output logic signed [AW-1:0] alpha,
   output logic                 done
);
   localparam int SW = qfs_pkg::max_i(AW, VW) + 1;
   localparam int PW = AW + SW;
   localparam logic signed [AW-1:0] ONE =
      {{(AW-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};
   localparam logic signed [PW-1:0] HI = {{(SW+1){1'b0}}, {(AW-1){1'b1}}};
   localparam logic signed [PW-1:0] LO = {{(SW+1){1'b1}}, {(AW-1){1'b0}}};

   if (FRAC < 1 || FRAC > AW - 2) begin : g_bad_frac
      $error("qfs_scale: FRAC must lie in 1..AW-2");
   end

   logic signed [SW-1:0] a_s, v_s, sum;
   logic signed [PW-1:0] a_p, s_p, prod, shr;
   logic signed [AW-1:0] nxt;

   assign a_s  = {{(SW-AW){alpha[AW-1]}}, alpha};
   assign v_s  = {{(SW-VW){v[VW-1]}}, v};
   assign sum  = a_s + v_s;
   assign a_p  = {{(PW-AW){alpha[AW-1]}}, alpha};
   assign s_p  = {{(PW-SW){sum[SW-1]}}, sum};
   assign prod = a_p * s_p;
   assign shr  = prod >>> FRAC;

   always_comb begin
      if (shr > HI)      nxt = HI[AW-1:0];
      else if (shr < LO) nxt = LO[AW-1:0];
      else               nxt = shr[AW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alpha <= ONE;
         done  <= 1'b0;
      end else begin
         done <= en & ~load & ~clr;
         if (clr)       alpha <= '0;
         else if (load) alpha <= ONE;
         else if (en)   alpha <= nxt;
      end
   end

   // R5: clear has top priority
   assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (alpha == '0));
   // R4: load restores unity
   assert_load_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (alpha == ONE));
   // R8: no control, no change
   assert_alpha_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && !en) |=> $stable(alpha));
   // R9: done follows a genuine update
   assert_done_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load && !clr) |=> done);
   // R9: done never appears without an update
   assert_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && !load && !clr) |=> !done);
   // R7: zero scale stays zero under the recurrence
   assert_zero_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load && !clr && alpha == '0) |=> (alpha == '0));

endmodule

// File: rtl/quad_scale_unit.sv
module quad_scale_unit
   import qfs_pkg::*;
#(
   parameter int M     = 4,
   parameter int DW    = 16,
   parameter int FRAC  = 12,
   parameter int AW    = 32,
   parameter bit MULT3 = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [M*DW-1:0]                      x_re_i,
   input  logic [M*DW-1:0]                      x_im_i,
   input  logic [M*DW-1:0]                      c_re_i,
   input  logic [M*DW-1:0]                      c_im_i,
   input  logic                                 mac_clr_i,
   input  logic                                 mac_en_i,
   input  logic                                 scale_load_i,
   input  logic                                 scale_clr_i,
   input  logic                                 scale_en_i,
   output logic signed [acc_w(DW, M)-FRAC-1:0]  v_o,
   output logic signed [AW-1:0]                 alpha_o,
   output logic                                 done_o
);
   localparam int ACC_W = acc_w(DW, M);
   localparam int VW    = ACC_W - FRAC;

   if (FRAC >= 2 * DW) begin : g_bad_frac
      $error("quad_scale_unit: FRAC must be below 2*DW");
   end

   logic signed [DW-1:0]    sx_re, sx_im, sc_re, sc_im;
   logic signed [ACC_W-1:0] acc_re, acc_im;

   qfs_serializer #(.M(M), .DW(DW)) i_ser (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (mac_clr_i),
      .step  (mac_en_i),
      .x_re  (x_re_i),
      .x_im  (x_im_i),
      .c_re  (c_re_i),
      .c_im  (c_im_i),
      .sx_re (sx_re),
      .sx_im (sx_im),
      .sc_re (sc_re),
      .sc_im (sc_im)
   );

   qfs_cmac #(.DW(DW), .ACC_W(ACC_W), .MULT3(MULT3)) i_mac (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (mac_clr_i),
      .en     (mac_en_i),
      .a_re   (sx_re),
      .a_im   (sx_im),
      .b_re   (sc_re),
      .b_im   (sc_im),
      .acc_re (acc_re),
      .acc_im (acc_im)
   );

   assign v_o = VW'(acc_re >>> FRAC);

   qfs_scale #(.AW(AW), .VW(VW), .FRAC(FRAC)) i_scale (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (scale_load_i),
      .clr   (scale_clr_i),
      .en    (scale_en_i),
      .v     (v_o),
      .alpha (alpha_o),
      .done  (done_o)
   );

   // R3: the imaginary sum never reaches the output
   logic unused_im;
   assign unused_im = ^acc_im;

endmodule

// File: tb/test_quad_scale_unit.sv
module test_quad_scale_unit;
   localparam int M    = 4;
   localparam int DW   = 16;
   localparam int FRAC = 12;
   localparam int AW   = 32;
   localparam int VW   = 2 * DW + $clog2(M) + 3 - FRAC;
   localparam longint ONE  = longint'(1) << FRAC;
   localparam longint AMAX = (longint'(1) << (AW - 1)) - 1;
   localparam longint AMIN = -(longint'(1) << (AW - 1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [M*DW-1:0] x_re, x_im, c_re, c_im;
   logic mac_clr = 0, mac_en = 0, s_load = 0, s_clr = 0, s_en = 0;
   logic signed [VW-1:0] v_o;
   logic signed [AW-1:0] alpha_o;
   logic done_o;

   int checks = 0;
   int errors = 0;
   int vxr[M], vxi[M], vcr[M], vci[M];
   longint exp_alpha;

   always #5 clk = ~clk;

   quad_scale_unit #(.M(M), .DW(DW), .FRAC(FRAC), .AW(AW)) i_quad_scale_unit (
      .clk(clk), .rst_n(rst_n),
      .x_re_i(x_re), .x_im_i(x_im), .c_re_i(c_re), .c_im_i(c_im),
      .mac_clr_i(mac_clr), .mac_en_i(mac_en),
      .scale_load_i(s_load), .scale_clr_i(s_clr), .scale_en_i(s_en),
      .v_o(v_o), .alpha_o(alpha_o), .done_o(done_o)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pack();
      for (int k = 0; k < M; k++) begin
         x_re[k*DW +: DW] = DW'(vxr[k]);
         x_im[k*DW +: DW] = DW'(vxi[k]);
         c_re[k*DW +: DW] = DW'(vcr[k]);
         c_im[k*DW +: DW] = DW'(vci[k]);
      end
   endtask

   task automatic set_vec(input int seed);
      for (int k = 0; k < M; k++) begin
         vxr[k] = ((seed * 53 + k * 97) % 3001) - 1500;
         vxi[k] = ((seed * 31 + k * 59) % 2001) - 1000;
         vcr[k] = ((seed * 17 + k * 83) % 2501) - 1250;
         vci[k] = ((seed * 71 + k * 13) % 1801) - 900;
      end
      pack();
   endtask

   function automatic longint term(input int k);
      return longint'(vxr[k]) * vcr[k] - longint'(vxi[k]) * vci[k];
   endfunction

   function automatic longint exp_v(input int n);
      longint s = 0;
      for (int j = 0; j < n; j++) s += term(j % M);
      return s >>> FRAC;
   endfunction

   function automatic longint next_alpha(input longint a, input longint v);
      logic signed [127:0] pa, ps, p;
      pa = a;
      ps = a + v;
      p  = (pa * ps) >>> FRAC;
      if (p > AMAX) return AMAX;
      if (p < AMIN) return AMIN;
      return longint'(p);
   endfunction

   // clear, then n enabled clocks; returns at a falling edge
   task automatic accumulate(input int n);
      mac_clr = 1;
      @(negedge clk);
      mac_clr = 0;
      mac_en  = 1;
      repeat (n) @(negedge clk);
      mac_en = 0;
   endtask

   task automatic update(input string req);
      exp_alpha = next_alpha(exp_alpha, longint'(v_o));
      s_en = 1;
      @(negedge clk);
      s_en = 0;
      chk({req, " alpha after update"}, longint'(alpha_o), exp_alpha);
      chk("R9 done high after update", longint'(done_o), 1);
      @(negedge clk);
      chk("R9 done single cycle", longint'(done_o), 0);
   endtask

   task automatic pulse_scale(input logic ld, input logic cl, input logic en);
      s_load = ld; s_clr = cl; s_en = en;
      @(negedge clk);
      s_load = 0; s_clr = 0; s_en = 0;
   endtask

   task automatic t_reset();
      chk("R1 reset alpha", longint'(alpha_o), ONE);
      chk("R1 reset v", longint'(v_o), 0);
      chk("R1 reset done", longint'(done_o), 0);
   endtask

   task automatic t_serial_order();
      set_vec(3);
      accumulate(1);
      chk("R2 first element only", longint'(v_o), exp_v(1));
      accumulate(3);
      chk("R2 three elements in order", longint'(v_o), exp_v(3));
      accumulate(M + 1);
      chk("R2 wrap to element 0", longint'(v_o), exp_v(M + 1));
      accumulate(1);
      chk("R2 clear rewinds counter", longint'(v_o), exp_v(1));
   endtask

   task automatic t_iterations();
      pulse_scale(1, 0, 0);
      exp_alpha = ONE;
      chk("R4 load before iterations", longint'(alpha_o), ONE);
      for (int it = 0; it < M; it++) begin
         set_vec(11 + it * 7);
         accumulate(M);
         chk("R3 full inner product", longint'(v_o), exp_v(M));
         update("R6");
      end
   endtask

   task automatic t_negative();
      for (int k = 0; k < M; k++) begin
         vxr[k] = 1001 + k; vxi[k] = 3; vcr[k] = -777; vci[k] = 5;
      end
      pack();
      accumulate(M);
      chk("R3 negative sum rounds down", longint'(v_o), exp_v(M));
      update("R6 negative v");
   endtask

   task automatic t_clear_hold();
      longint held;
      set_vec(5);
      accumulate(M);
      held = longint'(v_o);
      repeat (3) @(negedge clk);
      chk("R8 v held while idle", longint'(v_o), held);
      mac_clr = 1; mac_en = 1;
      @(negedge clk);
      mac_clr = 0; mac_en = 0;
      chk("R3 clear beats enable", longint'(v_o), 0);
   endtask

   task automatic t_scale_ctrl();
      longint held;
      held = longint'(alpha_o);
      repeat (4) @(negedge clk);
      chk("R8 alpha held while idle", longint'(alpha_o), held);
      pulse_scale(0, 1, 0);
      chk("R5 clear gives zero", longint'(alpha_o), 0);
      chk("R9 no done after clear", longint'(done_o), 0);
      pulse_scale(1, 0, 0);
      chk("R4 load gives one", longint'(alpha_o), ONE);
      pulse_scale(1, 1, 1);
      chk("R5 clear beats load and enable", longint'(alpha_o), 0);
      pulse_scale(1, 0, 1);
      chk("R4 load beats enable", longint'(alpha_o), ONE);
      chk("R9 no done after load", longint'(done_o), 0);
      pulse_scale(0, 1, 0);
      exp_alpha = 0;
      set_vec(9);
      accumulate(M);
      update("R6 zero alpha stays zero");
   endtask

   task automatic t_saturate();
      pulse_scale(1, 0, 0);
      exp_alpha = ONE;
      for (int k = 0; k < M; k++) begin
         vxr[k] = 32767; vxi[k] = 0; vcr[k] = 32767; vci[k] = 0;
      end
      pack();
      accumulate(M);
      chk("R3 full-scale inner product", longint'(v_o), exp_v(M));
      for (int r = 0; r < 3; r++) update("R7");
      chk("R7 saturated at positive limit", longint'(alpha_o), AMAX);
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      x_re = '0; x_im = '0; c_re = '0; c_im = '0;
      exp_alpha = ONE;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_serial_order();
      t_iterations();
      t_negative();
      t_clear_hold();
      t_scale_ctrl();
      t_saturate();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule